// File: doc/BRIEF.md
# Paged Virtual Address Translation Unit

This block sits between a processor and its memory bus. It turns a 16-bit virtual byte address into an 18-bit bus address. The virtual space is cut into eight pages of 8 KiB, and the top three address bits pick the page. Each page has a base register and a descriptor register. The base holds a click number, where one click is 64 bytes. The descriptor holds a 7-bit length in clicks, a flag that says which end of the page is valid, and separate read and write permission bits. The flag lets a region such as a stack be mapped from the top of a page, so it can grow downward.

There are two full sets of page registers, one for kernel mode and one for user mode. A previous-mode select lets a single access use the other mode's set, which supports moves between address spaces. When translation is disabled, a fixed map applies: pages 0 to 6 map to the same bus addresses, page 7 maps to the top 8 KiB of bus space, and no access faults. An access that falls outside the valid clicks, or that lacks the needed permission, raises a fault. On the clock edge of a fault, the program counter of that access is stored in a register that software can read back.

Top module: `pgx_xlate`

## Requirements
- R1: After reset, all 32 page registers are zero. With translation enabled, any read or write then faults, because both permission bits are clear, and the bus address equals the 13-bit page offset (base 0). After reset, `fault_pc` is 0.
- R2: With `xlat_en` low, `fault` stays low. Pages 0 to 6 give a bus address equal to the zero-extended virtual address. Page 7 gives `{2'b11, va}`, which is bus range 0x3E000 to 0x3FFFF.
- R3: With `xlat_en` high, `pa = base*64 + va[12:0]`, truncated to 18 bits. The base comes from the page that `va[15:13]` selects in the active set.
- R4: When the descriptor's upper flag (bit 7) is clear, click index `va[12:6]` is mapped only if it is less than or equal to the size field (bits 6:0). A larger index faults.
- R5: When the upper flag is set, click index `va[12:6]` is mapped only if it is greater than or equal to the size field. A smaller index faults.
- R6: A read faults when the descriptor's read bit (bit 8) is clear. A write faults when its write bit (bit 9) is clear.
- R7: `cur_mode` picks the set: 0 is kernel and 1 is user. A configuration write goes only to the set that `cfg_user` names, at the page `cfg_page`.
- R8: When `use_prev` is high, the access uses the set that `prev_mode` names instead of the one `cur_mode` names.
- R9: On each rising edge where `fault` is high, `fault_pc` takes `pc_in`. On every other edge, `fault_pc` keeps its value.
- R10: A configuration write with `cfg_desc` low loads `cfg_wdata[11:0]` into the base register. With `cfg_desc` high, it loads `cfg_wdata[9:0]` into the descriptor, using the layout {write, read, upper, size[6:0]}. The new value takes effect from the next cycle.
- R11: `fault` is low whenever `acc_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xlat_en | input | 1 | 1 = translate with the page registers, 0 = fixed map |
| cur_mode | input | 1 | Current mode: 0 kernel, 1 user |
| prev_mode | input | 1 | Previous mode, used when use_prev is high |
| use_prev | input | 1 | Use the previous mode's register set for this access |
| acc_valid | input | 1 | An access is being presented |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| va | input | 16 | Virtual byte address |
| pc_in | input | 16 | PC of the instruction making the access |
| cfg_we | input | 1 | Page register write strobe |
| cfg_user | input | 1 | Target set of the write: 0 kernel, 1 user |
| cfg_page | input | 3 | Target page of the write |
| cfg_desc | input | 1 | 1 = write the descriptor, 0 = write the base |
| cfg_wdata | input | 12 | Write data |
| pa | output | 18 | Bus address (combinational) |
| fault | output | 1 | Access fault (combinational) |
| fault_pc | output | 16 | PC latched at the last fault |

## Verification
`pa` and `fault` follow the access inputs in the same cycle, with no register in the path. The bench drives each access just after a falling edge and samples these two outputs a few nanoseconds later, before the next rising edge. `fault_pc` changes one rising edge after a faulting access, so the bench samples it 1 ns after that edge and compares it with a model that records `pc_in` only for accesses expected to fault. Page-register writes take effect one edge after the strobe, so every configuration write completes before the next access is driven.

// File: rtl/pgx_pkg.sv
package pgx_pkg;
    localparam int VA_W     = 16;
    localparam int PA_W     = 18;
    localparam int PG_SEL_W = 3;
    localparam int CLICK_W  = 6;
    localparam int NSETS    = 2;
    localparam int NPAGES   = 1 << PG_SEL_W;
    localparam int NREGS    = NSETS * NPAGES;
    localparam int OFF_W    = VA_W - PG_SEL_W;
    localparam int IDX_W    = OFF_W - CLICK_W;
    localparam int BASE_W   = PA_W - CLICK_W;
    localparam int RIDX_W   = $clog2(NREGS);

    // descriptor layout, low to high: size, upper, read, write
    typedef struct packed {
        logic             wr;
        logic             rd;
        logic             up;
        logic [IDX_W-1:0] size;
    } pgd_t;

    localparam int DESC_W = $bits(pgd_t);
endpackage

// File: rtl/pgx_regs.sv
module pgx_regs
    import pgx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic                we_set,
    input  logic [PG_SEL_W-1:0] we_page,
    input  logic                we_desc,
    input  logic [BASE_W-1:0]   wdata,
    input  logic                rd_set,
    input  logic [PG_SEL_W-1:0] rd_page,
    output logic [BASE_W-1:0]   rd_base,
    output pgd_t                rd_desc
);
    typedef struct packed {
        logic [NREGS-1:0][BASE_W-1:0] base;
        pgd_t [NREGS-1:0]             desc;
    } regs_t;

    regs_t regs_d, regs_q;
    logic [RIDX_W-1:0] wr_idx;
    logic [RIDX_W-1:0] rd_idx;

    assign wr_idx = {we_set, we_page};
    assign rd_idx = {rd_set, rd_page};

    always_comb begin
        regs_d = regs_q;
        if (we) begin
            if (we_desc) regs_d.desc[wr_idx] = pgd_t'(wdata[DESC_W-1:0]);
            else         regs_d.base[wr_idx] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign rd_base = regs_q.base[rd_idx];
    assign rd_desc = regs_q.desc[rd_idx];

    // R10
    base_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !we_desc) |=> regs_q.base[$past(wr_idx)] == $past(wdata));

    // R10
    desc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && we_desc) |=> regs_q.desc[$past(wr_idx)] == $past(wdata[DESC_W-1:0]));
endmodule

// File: rtl/pgx_chk.sv
module pgx_chk
    import pgx_pkg::*;
(
    input  pgd_t             desc,
    input  logic [IDX_W-1:0] idx,
    input  logic             valid,
    input  logic             write,
    output logic             viol
);
    logic mapped;
    logic allowed;

    always_comb begin
        if (desc.up) mapped = (idx >= desc.size);
        else         mapped = (idx <= desc.size);
        allowed = write ? desc.wr : desc.rd;
        viol    = valid && !(mapped && allowed);
    end
endmodule

// File: rtl/pgx_xlate.sv
module pgx_xlate
    import pgx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        xlat_en,
    input  logic        cur_mode,
    input  logic        prev_mode,
    input  logic        use_prev,
    input  logic        acc_valid,
    input  logic        acc_write,
    input  logic [15:0] va,
    input  logic [15:0] pc_in,
    input  logic        cfg_we,
    input  logic        cfg_user,
    input  logic [2:0]  cfg_page,
    input  logic        cfg_desc,
    input  logic [11:0] cfg_wdata,
    output logic [17:0] pa,
    output logic        fault,
    output logic [15:0] fault_pc
);
    typedef struct packed {
        logic [VA_W-1:0] fault_pc;
    } st_t;

    st_t st_d, st_q;

    logic                eff_set;
    logic [PG_SEL_W-1:0] page;
    logic [OFF_W-1:0]    offset;
    logic [BASE_W-1:0]   base;
    pgd_t                desc;
    logic                viol;

    assign eff_set = use_prev ? prev_mode : cur_mode;
    assign page    = va[VA_W-1:OFF_W];
    assign offset  = va[OFF_W-1:0];

    pgx_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .we_set  (cfg_user),
        .we_page (cfg_page),
        .we_desc (cfg_desc),
        .wdata   (cfg_wdata),
        .rd_set  (eff_set),
        .rd_page (page),
        .rd_base (base),
        .rd_desc (desc)
    );

    pgx_chk u_chk (
        .desc  (desc),
        .idx   (offset[OFF_W-1:CLICK_W]),
        .valid (acc_valid),
        .write (acc_write),
        .viol  (viol)
    );

    always_comb begin
        if (xlat_en) begin
            pa = {base, {CLICK_W{1'b0}}} + {{(PA_W-OFF_W){1'b0}}, offset};
        end else if (page == {PG_SEL_W{1'b1}}) begin
            pa = {{(PA_W-VA_W){1'b1}}, va};
        end else begin
            pa = {{(PA_W-VA_W){1'b0}}, va};
        end
        fault = xlat_en && viol;
    end

    always_comb begin
        st_d = st_q;
        if (fault) st_d.fault_pc = pc_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fault_pc = st_q.fault_pc;

    // R9
    fpc_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> fault_pc == $past(pc_in));

    // R9
    fpc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fault |=> $stable(fault_pc));

    // R2
    ident_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !xlat_en |-> (!fault && pa[OFF_W-1:0] == va[OFF_W-1:0]));

    // R3
    click_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xlat_en |-> pa[CLICK_W-1:0] == va[CLICK_W-1:0]);

    // R11
    quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> !fault);
endmodule

// File: tb/pgx_xlate_bench.sv
module pgx_xlate_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xlat_en = 1'b0, cur_mode = 1'b0, prev_mode = 1'b0, use_prev = 1'b0;
    logic        acc_valid = 1'b0, acc_write = 1'b0;
    logic [15:0] va = '0, pc_in = '0;
    logic        cfg_we = 1'b0, cfg_user = 1'b0, cfg_desc = 1'b0;
    logic [2:0]  cfg_page = '0;
    logic [11:0] cfg_wdata = '0;
    logic [17:0] pa;
    logic        fault;
    logic [15:0] fault_pc;

    int checks = 0;
    int fails  = 0;
    logic [15:0] exp_fpc = '0;

    always #4 clk = ~clk;

    pgx_xlate u_pgx_xlate (
        .clk(clk), .rst_n(rst_n), .xlat_en(xlat_en), .cur_mode(cur_mode),
        .prev_mode(prev_mode), .use_prev(use_prev), .acc_valid(acc_valid),
        .acc_write(acc_write), .va(va), .pc_in(pc_in), .cfg_we(cfg_we),
        .cfg_user(cfg_user), .cfg_page(cfg_page), .cfg_desc(cfg_desc),
        .cfg_wdata(cfg_wdata), .pa(pa), .fault(fault), .fault_pc(fault_pc)
    );

    // fields: req[44:41] en[40] mode[39] use_prev[38] prev[37] valid[36]
    //         write[35] va[34:19] exp_pa[18:1] exp_fault[0]
    localparam int NV = 14;
    localparam logic [44:0] VEC [NV] = '{
        {4'd4,  6'b100010, 16'h0140, 18'h04140, 1'b0}, // R4 last lower click
        {4'd4,  6'b100011, 16'h0180, 18'h04180, 1'b1}, // R4 beyond size
        {4'd5,  6'b100010, 16'h3F00, 18'h09F00, 1'b0}, // R5 first upper click
        {4'd5,  6'b100010, 16'h3EC0, 18'h09EC0, 1'b1}, // R5 below size
        {4'd6,  6'b100011, 16'h3F00, 18'h09F00, 1'b1}, // R6 write to read-only
        {4'd7,  6'b110011, 16'h0010, 18'h0C010, 1'b0}, // R7 user set
        {4'd8,  6'b111010, 16'h0140, 18'h04140, 1'b0}, // R8 user via kernel set
        {4'd8,  6'b101110, 16'h0010, 18'h0C010, 1'b0}, // R8 kernel via user set
        {4'd2,  6'b000011, 16'hE004, 18'h3E004, 1'b0}, // R2 top page redirect
        {4'd2,  6'b010010, 16'h1234, 18'h01234, 1'b0}, // R2 identity
        {4'd6,  6'b110010, 16'h4000, 18'h00000, 1'b1}, // R6 read of write-only
        {4'd6,  6'b110011, 16'h4000, 18'h00000, 1'b0}, // R6 write allowed
        {4'd11, 6'b100001, 16'h0180, 18'h04180, 1'b0}, // R11 no access
        {4'd1,  6'b110010, 16'h2000, 18'h00000, 1'b1}  // R1 untouched page
    };

    task automatic check(input bit ok, input int req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL R%0d %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic cfg(input logic user, input logic [2:0] pg, input logic dsc,
                       input logic [11:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_user = user; cfg_page = pg; cfg_desc = dsc; cfg_wdata = data;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic access(input logic [44:0] v, input logic [15:0] pc);
        int req;
        req = int'(v[44:41]);
        @(negedge clk);
        xlat_en = v[40]; cur_mode = v[39]; use_prev = v[38]; prev_mode = v[37];
        acc_valid = v[36]; acc_write = v[35]; va = v[34:19]; pc_in = pc;
        #2;
        check(fault == v[0], req, "fault", 32'(fault), 32'(v[0]));
        check(pa == v[18:1], req, "pa", 32'(pa), 32'(v[18:1]));
        if (v[0]) exp_fpc = pc;
        @(posedge clk); #1;
        // R9 capture on fault, hold otherwise
        check(fault_pc == exp_fpc, 9, "fault_pc", 32'(fault_pc), 32'(exp_fpc));
    endtask

    initial begin
        #(8 * 100000);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        #1 check(fault_pc == 16'h0, 1, "fault_pc reset", 32'(fault_pc), 32'h0);
        access({4'd1, 6'b100010, 16'h0000, 18'h00000, 1'b1}, 16'h0A00);
        access({4'd1, 6'b110011, 16'hE040, 18'h00040, 1'b1}, 16'h0A02);

        // R10 encodings: base in [11:0]; descriptor {wr,rd,up,size}
        cfg(1'b0, 3'd0, 1'b0, 12'h100);
        cfg(1'b0, 3'd0, 1'b1, 12'h305);  // rw, lower, size 5
        cfg(1'b0, 3'd1, 1'b0, 12'h200);
        cfg(1'b0, 3'd1, 1'b1, 12'h1FC);  // read only, upper, size 124
        cfg(1'b1, 3'd0, 1'b0, 12'h300);
        cfg(1'b1, 3'd0, 1'b1, 12'h37F);  // rw, lower, size 127
        cfg(1'b1, 3'd2, 1'b1, 12'h27F);  // write only, lower, size 127

        // R3 base plus offset across the table
        for (int i = 0; i < NV; i++) access(VEC[i], 16'h1000 + 16'(i));

        // R7 a kernel write left the user page 1 base untouched
        access({4'd7, 6'b110010, 16'h2040, 18'h00040, 1'b1}, 16'h2000);
        // R3 rebase a page and see the new address next access
        cfg(1'b0, 3'd0, 1'b0, 12'hFFF);
        access({4'd3, 6'b100010, 16'h0004, 18'h3FFC4, 1'b0}, 16'h2002);

        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule